// File: doc/BRIEF.md
# I2C Write-Only Target Receiver

This block is an I2C target that only accepts data. The bus controller drives the clock and the data bits; the block watches both lines and finds start and stop conditions. It compares the first byte after each start against its own 7-bit address, and it takes in the following bytes most significant bit first. Each completed byte, the address byte included, lands in a one-entry receive buffer. A host drains that buffer through a valid/ready pair. The block answers each byte it accepts with a programmable acknowledge bit. When the host has not emptied the buffer in time, the block stretches the clock.

Both bus lines are open-drain. The block never drives a line high. It reports on `scl_oe` and `sda_oe` when the pad should pull the line low, and it reads the resolved line levels on `scl_in` and `sda_in`.

Back-pressure on the receive stream works as follows. `rx_valid` stays high until a cycle in which `rx_ready` is also high; that cycle consumes the byte. `rx_ready` has no effect while `rx_valid` is low. A byte is never dropped, because when the next byte finishes while the buffer is still full, the block holds the bus clock low.

Top module: `i2c_rx_target`

## Requirements
- R1: During and right after reset, `scl_oe`, `sda_oe` and `rx_valid` are all 0.
- R2: While `enable` is 0 the block pulls neither line, returns no acknowledge and never raises `rx_valid`.
- R3: Only the first byte after a start is compared. It matches when its upper 7 bits equal `own_addr` and its lowest bit (R/W) is 0. On a mismatch the block leaves SDA released and ignores every later byte until the next start.
- R4: For a matching address byte and for each data byte after it, the block pulls SDA low during the 9th clock when the latched acknowledge value is 0, and leaves SDA released when that value is 1.
- R5: At the rising edge of the 9th clock of a matching address frame, `rx_valid` rises and `rx_data` holds the whole address byte (address followed by the R/W bit 0). The host discards it with a read.
- R6: Each data byte after a match is assembled MSB first. At the 9th clock rise it appears on `rx_data` with `rx_valid` high, whatever the acknowledge value.
- R7: A cycle with `rx_valid` and `rx_ready` both high consumes the byte, and `rx_valid` is 0 on the next cycle. `rx_ready` while `rx_valid` is 0 changes nothing.
- R8: If `rx_valid` is still 1 at the falling edge of the 8th clock of an accepted frame, `scl_oe` goes to 1 and stays there until the host consumes the buffer. The block then drives the acknowledge and releases SCL, and the new byte is delivered at the 9th clock rise.
- R9: The acknowledge value is sampled from `ack_level` at the first clock rise of each frame. A change made later in that frame, including one made while the clock is stretched, shows only in the next frame.
- R10: `sda_oe` changes only while the synchronized SCL is low, and SDA is released after the falling edge of the 9th clock.
- R11: A stop returns the block to idle with both lines released. Clock pulses with no start after a stop are ignored. A repeated start begins a new address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 forces idle and empties the buffer |
| own_addr | input | 7 | Target address to match |
| ack_level | input | 1 | Acknowledge bit to return (0 = ACK, 1 = NACK) |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_ready | input | 1 | Host accepts the buffered byte |
| rx_data | output | 8 | Buffered byte |

## Verification
The bench walks a table of frames that differ in how the address misses: one bit off at the low end, one bit off at the high end, the R/W bit set, and a data byte that would itself look like a matching address after a miss. A block that compared bytes other than the first, or that ignored the R/W bit, would acknowledge one of these frames. Stretching is tested by leaving the dummy address byte unread and changing `ack_level` while SCL is held. A design that did not stretch would overwrite the address byte. A design that sampled the acknowledge value late would return NACK for the stretched frame. The bench also sends bare clocks after a stop and a repeated start after a miss, which catch a block that keeps decoding after stop or that does not restart matching.

// File: rtl/i2c_rx_pkg.sv
`timescale 1ns/1ps
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
`timescale 1ns/1ps
module i2c_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_rx_linemon.sv
`timescale 1ns/1ps
module i2c_rx_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_ctrl.sv
`timescale 1ns/1ps
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_level,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic              buf_full,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  rx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              ack_frame;
  logic              addr_hit;

  assign addr_hit  = (shreg[DATA_W-1 -: ADDR_W] == own_addr) && !shreg[0];
  assign load      = (st == ST_ACK) && scl_rise;
  assign load_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ack_frame <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (!enable) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && cnt != LAST_BIT) begin
            shreg <= {shreg[DATA_W-2:0], sda_lvl};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == '0) ack_frame <= ack_level;
          end else if (scl_fall && cnt == LAST_BIT) begin
            if (st == ST_ADDR && !addr_hit) begin
              st <= ST_SKIP;
            end else if (buf_full) begin
              st     <= ST_HOLD;
              scl_oe <= 1'b1;
            end else begin
              st     <= ST_ACK;
              sda_oe <= ~ack_frame;
            end
          end
        end
        ST_HOLD: begin
          if (!buf_full) begin
            st     <= ST_ACK;
            sda_oe <= ~ack_frame;
          end
        end
        ST_ACK: begin
          scl_oe <= 1'b0;
          if (scl_fall) begin
            st     <= ST_DATA;
            cnt    <= '0;
            sda_oe <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rx_buffer.sv
`timescale 1ns/1ps
module i2c_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_ready,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!enable) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (rd_ready && full) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_target.sv
`timescale 1ns/1ps
module i2c_rx_target #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_level,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              load;
  logic [DATA_W-1:0] load_data;

  i2c_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout ({scl_s, sda_s})
  );

  i2c_rx_linemon u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_rx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .own_addr (own_addr),
    .ack_level(ack_level),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_lvl  (sda_s),
    .buf_full (rx_valid),
    .load     (load),
    .load_data(load_data),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

  i2c_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .load     (load),
    .load_data(load_data),
    .rd_ready (rx_ready),
    .full     (rx_valid),
    .data     (rx_data)
  );
endmodule

// File: rtl/i2c_rx_target_chk.sv
`timescale 1ns/1ps
module i2c_rx_target_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_s,
  input logic stop_det,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_valid,
  input logic rx_ready
);
  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    !$stable(sda_oe) |-> !scl_s);

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && rx_valid) |=> scl_oe);

  // R8
  stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> rx_valid);

  // R7
  consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_valid);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe && !rx_valid));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe));

  // R6
  load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> scl_s);
endmodule

bind i2c_rx_target i2c_rx_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .scl_s   (scl_s),
  .stop_det(stop_det),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready)
);

// File: tb/sim_i2c_rx_target.sv
`timescale 1ns/1ps
module sim_i2c_rx_target;
  localparam int H = 10;
  localparam logic [6:0] MY_ADDR = 7'h2A;
  // fields: [17:10] address byte, [9:2] data byte, [1] ack_level, [0] expected match
  localparam logic [17:0] VEC [0:7] = '{
    {8'h54, 8'hA5, 1'b0, 1'b1},
    {8'h54, 8'h3C, 1'b1, 1'b1},
    {8'h2A, 8'h54, 1'b0, 1'b0},
    {8'h55, 8'h5A, 1'b0, 1'b0},
    {8'h54, 8'h00, 1'b0, 1'b1},
    {8'h54, 8'hFF, 1'b0, 1'b1},
    {8'h56, 8'h54, 1'b0, 1'b0},
    {8'hD4, 8'h54, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic ack_level = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic rx_ready = 1'b0;
  logic scl_oe, sda_oe, rx_valid;
  logic [7:0] rx_data;
  logic scl_line, sda_line;
  logic ab;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rx_target u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(MY_ADDR),
    .ack_level(ack_level), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(H);
    scl_m = 1'b1; idle(H);
    sda_m = 1'b0; idle(H);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(H);
    scl_m = 1'b1; idle(H);
    sda_m = 1'b1; idle(H);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; idle(H);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(H);
    seen = sda_line;
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_byte(input logic [7:0] d, output logic ack_seen);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, ack_seen);
  endtask

  task automatic host_read();
    rx_ready = 1'b1; @(negedge clk);
    rx_ready = 1'b0; @(negedge clk);
  endtask

  initial begin
    idle(5);
    check(!scl_oe && !sda_oe && !rx_valid, "R1 in reset", {scl_oe, sda_oe, rx_valid}, 0);
    rst_n = 1'b1;
    idle(5);
    check(!scl_oe && !sda_oe && !rx_valid, "R1 after reset", {scl_oe, sda_oe, rx_valid}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, d;
      logic ak, m;
      {a, d, ak, m} = VEC[v];
      ack_level = ak;
      bus_start();
      bus_byte(a, ab);
      check(ab == (m ? ak : 1'b1), $sformatf("R3/R4 addr ack vec%0d", v), ab, m ? ak : 1'b1);
      check(rx_valid == m, $sformatf("R5 addr valid vec%0d", v), rx_valid, m);
      if (m) begin
        check(rx_data == a, $sformatf("R5 addr byte vec%0d", v), rx_data, a);
        host_read();
        check(!rx_valid, $sformatf("R7 drained vec%0d", v), rx_valid, 0);
      end
      check(!sda_oe, $sformatf("R10 released vec%0d", v), sda_oe, 0);
      bus_byte(d, ab);
      check(ab == (m ? ak : 1'b1), $sformatf("R4 data ack vec%0d", v), ab, m ? ak : 1'b1);
      check(rx_valid == m, $sformatf("R6/R3 data valid vec%0d", v), rx_valid, m);
      if (m) begin
        check(rx_data == d, $sformatf("R6 data byte vec%0d", v), rx_data, d);
        host_read();
      end
      bus_stop();
    end
    ack_level = 1'b0;

    // R7: ready while empty does nothing
    host_read();
    check(!rx_valid, "R7 idle ready", rx_valid, 0);

    // R8 / R9: stretch with dummy byte left unread, ack changed while held
    bus_start();
    bus_byte(8'h54, ab);
    check(ab == 1'b0 && rx_valid, "R5 addr before stretch", {ab, rx_valid}, 2'b01);
    fork
      bus_byte(8'hC3, ab);
      begin
        for (int i = 0; i < 3000 && !scl_oe; i++) @(negedge clk);
        check(scl_oe, "R8 stretch starts", scl_oe, 1);
        idle(40);
        check(scl_oe && !scl_line, "R8 stretch held", {scl_oe, scl_line}, 2'b10);
        check(rx_data == 8'h54, "R8 buffer kept", rx_data, 8'h54);
        ack_level = 1'b1;
        host_read();
      end
    join
    check(ab == 1'b0, "R9 old ack in stretched frame", ab, 0);
    check(rx_valid && rx_data == 8'hC3, "R8 byte after stretch", rx_data, 8'hC3);
    check(!scl_oe, "R8 released", scl_oe, 0);
    host_read();
    bus_byte(8'h81, ab);
    check(ab == 1'b1, "R9 new ack next frame", ab, 1);
    check(rx_valid && rx_data == 8'h81, "R6 after nack", rx_data, 8'h81);
    host_read();
    ack_level = 1'b0;
    bus_stop();

    // R11: clocks without start after stop
    scl_m = 1'b0; idle(H);
    bus_byte(8'h54, ab);
    check(ab == 1'b1 && !rx_valid, "R11 no start ignored", {ab, rx_valid}, 2'b10);
    bus_stop();

    // R11: repeated start after a miss
    bus_start();
    bus_byte(8'h2A, ab);
    check(ab == 1'b1, "R3 miss before restart", ab, 1);
    bus_start();
    bus_byte(8'h54, ab);
    check(ab == 1'b0 && rx_valid, "R11 repeated start matches", {ab, rx_valid}, 2'b01);
    host_read();
    bus_stop();
    check(!scl_oe && !sda_oe, "R11 stop releases", {scl_oe, sda_oe}, 0);

    // R2: disabled
    enable = 1'b0;
    idle(4);
    bus_start();
    bus_byte(8'h54, ab);
    check(ab == 1'b1 && !rx_valid, "R2 disabled", {ab, rx_valid}, 2'b10);
    bus_stop();
    enable = 1'b1;
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule